// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps the outcomes of the most recently resolved branches in a short global history register. That history picks one of several banks of 2-bit saturating counters. The low bits of the branch address then pick a row inside that bank. The counter's upper bit is the guess. Branches whose behaviour depends on the branches just before them therefore train separate counters for each recent context, and do not share a single counter for every path through the code.

A fetch stage presents a branch address on the lookup port. In the same cycle it receives the guess and the history value that produced it. The fetch stage carries that history value along with the branch. When the branch resolves, the execute stage returns the address, the actual direction and the carried history on the update port. The counter chosen by that history and address moves one step toward the outcome, and the outcome is shifted into the global history. No tag is stored. Any two branches with equal low address bits in the same history context use the same counter.

Top module: `corr_bpred`

## Requirements
- R1: A synchronous active-high reset sets the global history to 00 and every counter to 01 (weakly not-taken). After reset every lookup therefore predicts not-taken, and one taken update of an entry makes that entry predict taken.
- R2: `lk_taken` is combinational. It is the upper bit of the counter in bank `lk_hist` at row `lk_pc[4:0]`, so counter values 2 and 3 read as taken and values 0 and 1 read as not-taken.
- R3: An update with `up_taken`=1 raises the selected counter by one. A counter at 3 stays at 3.
- R4: An update with `up_taken`=0 lowers the selected counter by one. A counter at 0 stays at 0.
- R5: Each valid update shifts the history one place toward the MSB and puts the outcome in bit 0, so the next `lk_hist` is {old bit 0, `up_taken`}. `lk_hist` always shows the current history.
- R6: An update chooses its bank from `up_hist`, not from the current history register.
- R7: Address bits above bit 4 are ignored. PCs with equal `pc[4:0]` share an entry in each bank.
- R8: An update changes only the one counter it selects. The same row in the other banks is left unchanged.
- R9: While `up_valid` is 0, the update inputs change neither the counters nor the history.
- R10: A lookup of the entry being updated in the same cycle returns the value from before the update. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_BITS | Address of the branch being looked up |
| lk_taken | output | 1 | Prediction: 1 means taken |
| lk_hist | output | HIST_BITS | Current global history; the fetch stage carries it with the branch |
| up_valid | input | 1 | An update is presented this cycle |
| up_pc | input | PC_BITS | Address of the resolved branch |
| up_hist | input | HIST_BITS | History that was current when the resolved branch was predicted |
| up_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The bench drives each counter past both ends. A counter that wraps instead of holding flips its guess after one update in the other direction, and the bench sees the wrong guess. It trains a row under a carried history that differs from the live history. A design that indexed updates with the live register would train the wrong bank, and the bench catches it by reading that row back in both contexts. It also aims at three more faults: entries that alias only when the upper address bits are equal, an update that leaks into a neighbouring bank or applies while `up_valid` is low, and a same-cycle lookup that returns the new value instead of the old one.

// File: rtl/corr_bpred_pkg.sv
package corr_bpred_pkg;

  // Default geometry of the predictor.
  localparam int DEF_PC_BITS   = 32;
  localparam int DEF_HIST_BITS = 2;
  localparam int DEF_ROW_BITS  = 5;
  localparam int DEF_CTR_BITS  = 2;

  // Weakly not-taken: one step below the taken threshold.
  function automatic int ctr_init_value(input int ctr_bits);
    return (1 << (ctr_bits - 1)) - 1;
  endfunction

  // Counters are kept in a table with this many entries.
  function automatic int table_depth(input int hist_bits, input int row_bits);
    return 1 << (hist_bits + row_bits);
  endfunction

endpackage

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int HB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [HB-1:0] hist_q
);

  logic [HB-1:0] hist_d;

  generate
    if (HB == 1) begin : g_single
      assign hist_d = bit_in;
    end else begin : g_shift
      assign hist_d = {hist_q[HB-2:0], bit_in};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= hist_d;
    end
  end

endmodule

// File: rtl/bp_index.sv
module bp_index #(
  parameter int PCW = 32,
  parameter int HB  = 2,
  parameter int RB  = 5,
  localparam int IW = HB + RB
) (
  input  logic [HB-1:0]  hist,
  input  logic [PCW-1:0] pc,
  output logic [IW-1:0]  idx
);

  // Bank number from history in the upper field, row from the PC below it.
  assign idx = {hist, pc[RB-1:0]};

  logic pc_hi_unused;
  assign pc_hi_unused = ^pc[PCW-1:RB];

endmodule

// File: rtl/bp_sat_step.sv
module bp_sat_step #(
  parameter int W = 2
) (
  input  logic [W-1:0] cur,
  input  logic         taken,
  output logic [W-1:0] nxt
);

  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] BOT = '0;
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    if (taken) begin
      nxt = (cur == TOP) ? cur : cur + ONE;
    end else begin
      nxt = (cur == BOT) ? cur : cur - ONE;
    end
  end

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int HB = 2,
  parameter int RB = 5,
  parameter int W  = 2,
  localparam int IW    = HB + RB,
  localparam int DEPTH = corr_bpred_pkg::table_depth(HB, RB),
  localparam logic [W-1:0] INIT = W'(corr_bpred_pkg::ctr_init_value(W))
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_ctr,
  input  logic [IW-1:0] wr_idx,
  output logic [W-1:0]  wr_cur,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_ctr
);

  logic [W-1:0] mem [DEPTH];

  assign rd_ctr = mem[rd_idx];
  assign wr_cur = mem[wr_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= INIT;
      end
    end else if (wr_en) begin
      mem[wr_idx] <= wr_ctr;
    end
  end

endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
  parameter int PC_BITS   = corr_bpred_pkg::DEF_PC_BITS,
  parameter int HIST_BITS = corr_bpred_pkg::DEF_HIST_BITS,
  parameter int ROW_BITS  = corr_bpred_pkg::DEF_ROW_BITS,
  parameter int CTR_BITS  = corr_bpred_pkg::DEF_CTR_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PC_BITS-1:0]   lk_pc,
  output logic                 lk_taken,
  output logic [HIST_BITS-1:0] lk_hist,
  input  logic                 up_valid,
  input  logic [PC_BITS-1:0]   up_pc,
  input  logic [HIST_BITS-1:0] up_hist,
  input  logic                 up_taken
);

  localparam int IW = HIST_BITS + ROW_BITS;
  localparam int NPORT = 2;   // port 0 = lookup, port 1 = update

  logic [HIST_BITS-1:0] ghr_q;
  logic [NPORT-1:0][HIST_BITS-1:0] port_hist;
  logic [NPORT-1:0][PC_BITS-1:0]   port_pc;
  logic [NPORT-1:0][IW-1:0]        port_idx;
  logic [CTR_BITS-1:0] look_ctr;
  logic [CTR_BITS-1:0] upd_cur;
  logic [CTR_BITS-1:0] upd_nxt;

  assign port_hist[0] = ghr_q;
  assign port_pc[0]   = lk_pc;
  assign port_hist[1] = up_hist;
  assign port_pc[1]   = up_pc;

  generate
    for (genvar g = 0; g < NPORT; g++) begin : g_idx
      bp_index #(
        .PCW(PC_BITS), .HB(HIST_BITS), .RB(ROW_BITS)
      ) u_idx (
        .hist (port_hist[g]),
        .pc   (port_pc[g]),
        .idx  (port_idx[g])
      );
    end
  endgenerate

  bp_ghist #(.HB(HIST_BITS)) u_ghist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (up_valid),
    .bit_in   (up_taken),
    .hist_q   (ghr_q)
  );

  bp_ctr_table #(
    .HB(HIST_BITS), .RB(ROW_BITS), .W(CTR_BITS)
  ) u_tab (
    .clk    (clk),
    .rst    (rst),
    .rd_idx (port_idx[0]),
    .rd_ctr (look_ctr),
    .wr_idx (port_idx[1]),
    .wr_cur (upd_cur),
    .wr_en  (up_valid),
    .wr_ctr (upd_nxt)
  );

  bp_sat_step #(.W(CTR_BITS)) u_step (
    .cur   (upd_cur),
    .taken (up_taken),
    .nxt   (upd_nxt)
  );

  assign lk_taken = look_ctr[CTR_BITS-1];
  assign lk_hist  = ghr_q;

endmodule

// File: rtl/corr_bpred_chk.sv
module corr_bpred_chk #(
  parameter int HB = 2,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [HB-1:0] lk_hist,
  input logic          up_valid,
  input logic          up_taken,
  input logic [CW-1:0] upd_cur,
  input logic [CW-1:0] upd_nxt
);

  logic [HB-1:0] shifted;
  generate
    if (HB == 1) begin : g_one
      assign shifted = up_taken;
    end else begin : g_many
      assign shifted = {lk_hist[HB-2:0], up_taken};
    end
  endgenerate

  // R1: history is zero on the first cycle after reset is released
  a_r1_hist_cleared: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> lk_hist == '0);

  // R5: a valid update shifts the outcome in at bit 0
  a_r5_hist_shift: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> lk_hist == $past(shifted));

  // R9: no update, no history change
  a_r9_hist_hold: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> $stable(lk_hist));

  // R3: a taken outcome never lowers a counter and never leaves it at zero
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_taken) |-> (upd_nxt >= upd_cur) && (upd_nxt != '0));

  // R4: a not-taken outcome never raises a counter and never leaves it at the top
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !up_taken) |-> (upd_nxt <= upd_cur) && (upd_nxt != '1));

endmodule

bind corr_bpred corr_bpred_chk #(.HB(HIST_BITS), .CW(CTR_BITS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .lk_hist  (lk_hist),
  .up_valid (up_valid),
  .up_taken (up_taken),
  .upd_cur  (upd_cur),
  .upd_nxt  (upd_nxt)
);

// File: tb/corr_bpred_test.sv
`timescale 1ns/1ps
module corr_bpred_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_pc = '0;
  logic        lk_taken;
  logic [1:0]  lk_hist;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic [1:0]  up_hist = '0;
  logic        up_taken = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  corr_bpred uut (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_hist(lk_hist),
    .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_taken(up_taken)
  );

  typedef struct {
    string      tag;
    logic       exp_t;
    logic [1:0] exp_h;
  } sb_item_t;

  sb_item_t sb[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Reference state built from the requirements.
  int         mdl [4][32];
  logic [1:0] mh;

  // Driver: one cycle of stimulus, expected result pushed to the scoreboard.
  task automatic step(input logic uv, input logic [31:0] upc, input logic [1:0] uh,
                      input logic ut, input logic [31:0] lpc, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    up_valid = uv; up_pc = upc; up_hist = uh; up_taken = ut; lk_pc = lpc;
    it.tag   = tag;
    it.exp_t = (mdl[mh][lpc[4:0]] >= 2);   // R2: upper bit of the counter
    it.exp_h = mh;
    sb.push_back(it);
    if (uv) begin
      if (ut) begin
        if (mdl[uh][upc[4:0]] < 3) mdl[uh][upc[4:0]]++;
      end else begin
        if (mdl[uh][upc[4:0]] > 0) mdl[uh][upc[4:0]]--;
      end
      mh = {mh[0], ut};
    end
  endtask

  // Bring the history to h through updates on a spare entry (bank 3, row 20).
  task automatic set_hist(input logic [1:0] h, input logic [31:0] lpc, input string tag);
    step(1'b1, 32'd20, 2'd3, h[1], lpc, tag);
    step(1'b1, 32'd20, 2'd3, h[0], lpc, tag);
  endtask

  // Monitor: compares at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      sb_item_t it;
      it = sb.pop_front();
      n_chk++;
      if (lk_taken !== it.exp_t || lk_hist !== it.exp_h) begin
        n_fail++;
        $display("FAIL %s: taken=%b hist=%b expected taken=%b hist=%b",
                 it.tag, lk_taken, lk_hist, it.exp_t, it.exp_h);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 32; r++)
        mdl[b][r] = 1;
    mh = 2'b00;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state, not-taken everywhere, history 00
    step(1'b0, 32'd0, 2'd0, 1'b0, 32'd0,  "R1 reset pc0");
    step(1'b0, 32'd0, 2'd0, 1'b0, 32'd5,  "R1 reset pc5");
    step(1'b0, 32'd0, 2'd0, 1'b0, 32'd31, "R1 reset pc31");
    // R1/R10: one taken step from 01 gives taken; same-cycle lookup sees old value
    step(1'b1, 32'd11, 2'd0, 1'b1, 32'd11, "R10 same-cycle old value");
    set_hist(2'b00, 32'd11, "R5 history walk");
    step(1'b0, 32'd0, 2'd0, 1'b0, 32'd11, "R1 init 01 plus one is taken");

    // R3: saturate at 3, then one decrement still predicts taken
    for (int k = 0; k < 5; k++) step(1'b1, 32'd3, 2'd0, 1'b1, 32'd3, "R3 train up");
    step(1'b1, 32'd3, 2'd0, 1'b0, 32'd3, "R3 one down");
    set_hist(2'b00, 32'd3, "R5 history walk");
    step(1'b0, 32'd0, 2'd0, 1'b0, 32'd3, "R3 saturated at 3");
    step(1'b1, 32'd3, 2'd0, 1'b0, 32'd3, "R2 down to 1");
    set_hist(2'b00, 32'd3, "R5 history walk");
    step(1'b0, 32'd0, 2'd0, 1'b0, 32'd3, "R2 value 1 not-taken");

    // R4: saturate at 0, then one increment still predicts not-taken
    for (int k = 0; k < 4; k++) step(1'b1, 32'd7, 2'd0, 1'b0, 32'd7, "R4 train down");
    step(1'b1, 32'd7, 2'd0, 1'b1, 32'd7, "R4 one up");
    set_hist(2'b00, 32'd7, "R5 history walk");
    step(1'b0, 32'd0, 2'd0, 1'b0, 32'd7, "R4 saturated at 0");
    step(1'b1, 32'd7, 2'd0, 1'b1, 32'd7, "R4 up to 2");
    set_hist(2'b00, 32'd7, "R5 history walk");
    step(1'b0, 32'd0, 2'd0, 1'b0, 32'd7, "R4 value 2 taken");

    // R6/R8: train bank 1 while live history is 3
    set_hist(2'b11, 32'd9, "R5 to 11");
    step(1'b1, 32'd9, 2'd1, 1'b1, 32'd9, "R6 carried history");
    step(1'b1, 32'd9, 2'd1, 1'b1, 32'd9, "R6 carried history");
    set_hist(2'b01, 32'd9, "R5 to 01");
    step(1'b0, 32'd0, 2'd0, 1'b0, 32'd9, "R6 bank 1 trained");
    set_hist(2'b11, 32'd9, "R5 to 11");
    step(1'b0, 32'd0, 2'd0, 1'b0, 32'd9, "R8 bank 3 untouched");
    set_hist(2'b00, 32'd9, "R5 to 00");
    step(1'b0, 32'd0, 2'd0, 1'b0, 32'd9, "R8 bank 0 untouched");

    // R7: aliasing through low five bits
    set_hist(2'b01, 32'h0000_1009, "R5 to 01");
    step(1'b0, 32'd0, 2'd0, 1'b0, 32'hABC0_0009, "R7 alias high bits");
    step(1'b0, 32'd0, 2'd0, 1'b0, 32'h0000_0029, "R7 alias row 9");
    step(1'b0, 32'd0, 2'd0, 1'b0, 32'h0000_000A, "R7 neighbour row");

    // R9: update inputs without up_valid change nothing
    for (int k = 0; k < 4; k++)
      step(1'b0, 32'd9, 2'd1, 1'b0, 32'd9, "R9 invalid update ignored");
    step(1'b0, 32'd0, 2'd0, 1'b0, 32'd9, "R9 entry still taken");

    // R5: distinct shift patterns
    step(1'b1, 32'd14, 2'd2, 1'b1, 32'd14, "R5 shift 1");
    step(1'b1, 32'd14, 2'd2, 1'b0, 32'd14, "R5 shift 0");
    step(1'b1, 32'd15, 2'd0, 1'b1, 32'd14, "R5 shift 1");
    step(1'b0, 32'd0,  2'd0, 1'b0, 32'd14, "R5 final history");

    step(1'b0, 32'd0, 2'd0, 1'b0, 32'd0, "drain");
    while (sb.size() > 0) @(negedge clk);
    @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule